// File: doc/BRIEF.md
# Serial Flash Power-Mode Command Responder

This block is the target-side logic of a serial memory port that deals with two power instructions only. One puts the part to sleep (opcode 0xB9). The other either wakes it or returns an 8-bit identity byte (opcode 0xAB). The serial pins (select, clock, data in) are brought into the system clock domain. Each frame is counted to the bit. The command is judged at the moment select is released. Every entry and exit delay is a count of system clock cycles.

The host sees a two-bit power state and a serial data output that has its own enable. A busy flag from a separate program/erase engine stops the sleep command from being taken while that engine is working. The block comes out of reset in standby. While asleep it ignores all traffic except the wake/identity opcode.

Top module: `pm_cmd_responder`

## Requirements
- R1: After reset, `pwr_state` is STANDBY (2'b00) and `spi_do_oe` is low.
- R2: In STANDBY, a frame of exactly 8 bits carrying 0xB9 (MSB first), with `busy` low when select rises, makes `pwr_state` ENTERING (2'b01) for exactly T_DP clock cycles and then DEEP (2'b10).
- R3: A 0xB9 frame ended after 7 bits, or after 9 or more bits, leaves `pwr_state` at STANDBY.
- R4: A valid 0xB9 frame that ends while `busy` is high is discarded, and `pwr_state` stays STANDBY.
- R5: In DEEP, any frame whose first byte is not 0xAB is ignored, and so is a 0xAB frame shorter than 8 bits. `pwr_state` stays DEEP and `spi_do_oe` stays low.
- R6: In DEEP, a frame of exactly 8 bits carrying 0xAB makes `pwr_state` WAKING (2'b11) for exactly T_RES1 cycles and then STANDBY.
- R7: In STANDBY or DEEP, a frame of 0xAB followed by three dummy bytes drives the DEV_ID byte on `spi_do`, MSB first. The first bit appears on the falling clock edge that follows the 32nd rising edge. A new bit appears on each later falling edge, and the byte repeats every 8 bits while select stays low.
- R8: A 0xAB frame longer than 8 bits that ends while in DEEP gives WAKING for exactly T_RES2 cycles and then STANDBY. The same frame in STANDBY leaves the state at STANDBY.
- R9: `spi_do_oe` is low whenever the identity byte is not being shifted, and it falls within a few cycles of select going high.
- R10: Frames received while in ENTERING or WAKING have no effect. A 0xAB wake frame sent during ENTERING still leaves the block in DEEP once the entry delay ends.
- R11: In STANDBY, a bare 8-bit 0xAB frame leaves `pwr_state` at STANDBY.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all delays are counted on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sclk | input | 1 | Serial clock, idle low (mode 0) |
| spi_di | input | 1 | Serial data in, sampled on rising serial clock |
| busy | input | 1 | High while an external program/erase cycle runs |
| spi_do | output | 1 | Serial data out (identity byte) |
| spi_do_oe | output | 1 | Output enable for `spi_do` |
| pwr_state | output | 2 | 00 standby, 01 entering, 10 deep, 11 waking |

## Verification
The hardest case to reach is a select release that lands exactly on a byte boundary as opposed to one bit before or after it. This case alone separates an accepted sleep command from a discarded one. The bench builds every frame bit by bit, so it can end frames after 7, 8 and 9 bits. It also sends a wake frame inside the entry window to show that transitional states swallow traffic. Each delay length is measured by counting how many clock cycles the state output holds its transitional code.

// File: rtl/pm_pkg.sv
package pm_pkg;

  typedef enum logic [1:0] {
    PS_STANDBY = 2'b00,
    PS_ENTER   = 2'b01,
    PS_DEEP    = 2'b10,
    PS_WAKE    = 2'b11
  } pwr_state_e;

  localparam logic [7:0] OPC_SLEEP   = 8'hB9;
  localparam logic [7:0] OPC_WAKE_ID = 8'hAB;

  localparam int BIT_W  = 3;
  localparam int BYTE_W = 3;

  // Bytes in a read-identity header: opcode plus three dummy bytes.
  localparam int ID_HDR_BYTES = 4;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Width needed to hold a reload value of (cycles - 1).
  function automatic int cnt_width(input int max_cycles);
    int w;
    w = $clog2(max_cycles);
    return (w < 1) ? 1 : w;
  endfunction

  // A state held for N cycles is loaded with N-1 and left at zero.
  function automatic int delay_load(input int cycles);
    return cycles - 1;
  endfunction

  // A frame whose select rose right after the eighth latched bit.
  function automatic logic frame_exact8(input logic [BYTE_W-1:0] bytes,
                                        input logic [BIT_W-1:0] bits);
    return (bytes == BYTE_W'(1)) && (bits == '0);
  endfunction

  // A frame that carried at least one bit past the opcode.
  function automatic logic frame_beyond8(input logic [BYTE_W-1:0] bytes,
                                         input logic [BIT_W-1:0] bits);
    return (bytes > BYTE_W'(1)) || ((bytes == BYTE_W'(1)) && (bits != '0));
  endfunction

endpackage

// File: rtl/pm_spi_front.sv
module pm_spi_front
  import pm_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_in,
  input  logic              sclk_in,
  input  logic              di_in,
  output logic              cs_low,
  output logic              cs_rise,
  output logic              sclk_fall,
  output logic              byte_done,
  output logic [BIT_W-1:0]  bit_cnt,
  output logic [BYTE_W-1:0] byte_cnt,
  output logic [7:0]        opcode
);

  logic [SYNC-1:0] cs_sync, sclk_sync, di_sync;
  logic            cs_d, sclk_d;
  logic            cs_s, sclk_s, di_s;
  logic            sclk_rise;
  logic [6:0]      shreg;

  // Synchroniser chains, one per pin, built by the same generate.
  generate
    if (SYNC == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cs_sync   <= '1;
          sclk_sync <= '0;
          di_sync   <= '0;
        end else begin
          cs_sync   <= cs_n_in;
          sclk_sync <= sclk_in;
          di_sync   <= di_in;
        end
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cs_sync   <= '1;
          sclk_sync <= '0;
          di_sync   <= '0;
        end else begin
          cs_sync   <= {cs_sync[SYNC-2:0], cs_n_in};
          sclk_sync <= {sclk_sync[SYNC-2:0], sclk_in};
          di_sync   <= {di_sync[SYNC-2:0], di_in};
        end
      end
    end
  endgenerate

  assign cs_s   = cs_sync[SYNC-1];
  assign sclk_s = sclk_sync[SYNC-1];
  assign di_s   = di_sync[SYNC-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
    end
  end

  assign cs_low    = !cs_s;
  assign cs_rise   = cs_s && !cs_d;
  assign sclk_rise = sclk_s && !sclk_d && cs_low;
  assign sclk_fall = !sclk_s && sclk_d && cs_low;
  assign byte_done = sclk_rise && (bit_cnt == BIT_W'(7));

  // Bit and byte counters; cleared whenever select is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
      shreg    <= '0;
      opcode   <= '0;
    end else if (!cs_low) begin
      bit_cnt  <= '0;
      byte_cnt <= '0;
    end else if (sclk_rise) begin
      shreg   <= {shreg[5:0], di_s};
      bit_cnt <= bit_cnt + BIT_W'(1);
      if (byte_done) begin
        if (byte_cnt != '1) byte_cnt <= byte_cnt + BYTE_W'(1);
        if (byte_cnt == '0) opcode <= {shreg, di_s};
      end
    end
  end

  p_count_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_low |=> (bit_cnt == '0) && (byte_cnt == '0));

endmodule

// File: rtl/pm_delay_timer.sv
module pm_delay_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         running,
  output logic         expire
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b0;
    end else if (load) begin
      cnt     <= load_val;
      running <= 1'b1;
    end else if (running) begin
      if (cnt == '0) running <= 1'b0;
      else           cnt     <= cnt - W'(1);
    end
  end

  assign expire = running && (cnt == '0);

  p_expire_ends_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !load) |=> !running);

endmodule

// File: rtl/pm_power_fsm.sv
module pm_power_fsm
  import pm_pkg::*;
#(
  parameter int T_DP   = 64,
  parameter int T_RES1 = 32,
  parameter int T_RES2 = 48,
  parameter int W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_rise,
  input  logic [BIT_W-1:0]  bit_cnt,
  input  logic [BYTE_W-1:0] byte_cnt,
  input  logic [7:0]        opcode,
  input  logic              busy,
  input  logic              tmr_expire,
  output logic              tmr_load,
  output logic [W-1:0]      tmr_val,
  output pwr_state_e        state
);

  logic exact8, beyond8;
  logic sleep_req, sleep_go, wake_short, wake_after_id;

  assign exact8  = frame_exact8(byte_cnt, bit_cnt);
  assign beyond8 = frame_beyond8(byte_cnt, bit_cnt);

  // Named decode events, used by the assertions below.
  assign sleep_req     = cs_rise && exact8 && (opcode == OPC_SLEEP) && (state == PS_STANDBY);
  assign sleep_go      = sleep_req && !busy;
  assign wake_short    = cs_rise && exact8 && (opcode == OPC_WAKE_ID) && (state == PS_DEEP);
  assign wake_after_id = cs_rise && beyond8 && (opcode == OPC_WAKE_ID) && (state == PS_DEEP);

  always_comb begin
    tmr_load = sleep_go || wake_short || wake_after_id;
    if (sleep_go)        tmr_val = W'(delay_load(T_DP));
    else if (wake_short) tmr_val = W'(delay_load(T_RES1));
    else                 tmr_val = W'(delay_load(T_RES2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PS_STANDBY;
    end else begin
      unique case (state)
        PS_STANDBY: if (sleep_go) state <= PS_ENTER;
        PS_ENTER:   if (tmr_expire) state <= PS_DEEP;
        PS_DEEP:    if (wake_short || wake_after_id) state <= PS_WAKE;
        PS_WAKE:    if (tmr_expire) state <= PS_STANDBY;
        default:    state <= PS_STANDBY;
      endcase
    end
  end

  p_enter_from_standby_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_ENTER && $past(state) != PS_ENTER) |-> $past(state) == PS_STANDBY);

  p_busy_discard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_req && busy) |=> state == PS_STANDBY);

  p_deep_exit_waking_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == PS_DEEP && state != PS_DEEP) |-> state == PS_WAKE);

  p_waking_to_standby_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == PS_WAKE && state != PS_WAKE) |-> state == PS_STANDBY);

  p_enter_to_deep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == PS_ENTER && state != PS_ENTER) |-> state == PS_DEEP);

endmodule

// File: rtl/pm_id_shifter.sv
module pm_id_shifter
  import pm_pkg::*;
#(
  parameter logic [7:0] DEV_ID = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_low,
  input  logic              sclk_fall,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_cnt,
  input  logic [7:0]        opcode,
  input  pwr_state_e        state,
  output logic              do_bit,
  output logic              do_oe
);

  logic       armed;
  logic       arm;
  logic [2:0] idx;

  // Arm once the last dummy byte has been latched after a 0xAB opcode.
  assign arm = byte_done && (byte_cnt == BYTE_W'(ID_HDR_BYTES - 1)) &&
               (opcode == OPC_WAKE_ID) &&
               ((state == PS_STANDBY) || (state == PS_DEEP));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      idx    <= 3'd7;
      do_bit <= 1'b0;
      do_oe  <= 1'b0;
    end else if (!cs_low) begin
      armed  <= 1'b0;
      idx    <= 3'd7;
      do_bit <= 1'b0;
      do_oe  <= 1'b0;
    end else begin
      if (arm) armed <= 1'b1;
      if (armed && sclk_fall) begin
        do_bit <= DEV_ID[idx];
        idx    <= idx - 3'd1;
        do_oe  <= 1'b1;
      end
    end
  end

  p_oe_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (do_oe && !cs_low) |=> !do_oe);

  p_oe_needs_ab_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(do_oe) |-> opcode == OPC_WAKE_ID);

endmodule

// File: rtl/pm_cmd_responder.sv
module pm_cmd_responder
  import pm_pkg::*;
#(
  parameter int         T_DP        = 64,
  parameter int         T_RES1      = 32,
  parameter int         T_RES2      = 48,
  parameter logic [7:0] DEV_ID      = 8'h14,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       spi_cs_n,
  input  logic       spi_sclk,
  input  logic       spi_di,
  input  logic       busy,
  output logic       spi_do,
  output logic       spi_do_oe,
  output logic [1:0] pwr_state
);

  localparam int TW = cnt_width(max3(T_DP, T_RES1, T_RES2));

  logic              cs_low, cs_rise, sclk_fall, byte_done;
  logic [BIT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] byte_cnt;
  logic [7:0]        opcode;
  logic              tmr_load, tmr_running, tmr_expire;
  logic [TW-1:0]     tmr_val;
  pwr_state_e        state;

  pm_spi_front #(.SYNC(SYNC_STAGES)) u_front (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_in   (spi_cs_n),
    .sclk_in   (spi_sclk),
    .di_in     (spi_di),
    .cs_low    (cs_low),
    .cs_rise   (cs_rise),
    .sclk_fall (sclk_fall),
    .byte_done (byte_done),
    .bit_cnt   (bit_cnt),
    .byte_cnt  (byte_cnt),
    .opcode    (opcode)
  );

  pm_delay_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .running  (tmr_running),
    .expire   (tmr_expire)
  );

  pm_power_fsm #(.T_DP(T_DP), .T_RES1(T_RES1), .T_RES2(T_RES2), .W(TW)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_rise    (cs_rise),
    .bit_cnt    (bit_cnt),
    .byte_cnt   (byte_cnt),
    .opcode     (opcode),
    .busy       (busy),
    .tmr_expire (tmr_expire),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .state      (state)
  );

  pm_id_shifter #(.DEV_ID(DEV_ID)) u_id (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_low    (cs_low),
    .sclk_fall (sclk_fall),
    .byte_done (byte_done),
    .byte_cnt  (byte_cnt),
    .opcode    (opcode),
    .state     (state),
    .do_bit    (spi_do),
    .do_oe     (spi_do_oe)
  );

  assign pwr_state = state;

  // The timer only runs inside a transitional state.
  p_timer_in_transit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_running |-> (state == PS_ENTER || state == PS_WAKE));

  p_oe_only_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
    spi_do_oe |-> (state == PS_STANDBY || state == PS_DEEP));

endmodule

// File: tb/test_pm_cmd_responder.sv
module test_pm_cmd_responder;

  localparam int         T_DP   = 150;
  localparam int         T_RES1 = 40;
  localparam int         T_RES2 = 60;
  localparam logic [7:0] ID     = 8'hC5;
  localparam int         H      = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, di = 1'b0, busy = 1'b0;
  logic do_w, do_oe;
  logic [1:0] st;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  pm_cmd_responder #(.T_DP(T_DP), .T_RES1(T_RES1), .T_RES2(T_RES2),
                     .DEV_ID(ID), .SYNC_STAGES(2)) i_pm_cmd_responder (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk),
    .spi_di(di), .busy(busy), .spi_do(do_w), .spi_do_oe(do_oe),
    .pwr_state(st));

  task automatic wcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sel();
    cs_n = 1'b0; wcyc(H);
  endtask

  task automatic desel();
    wcyc(H); cs_n = 1'b1;
  endtask

  task automatic clk_bit(input logic d);
    di = d; wcyc(H); sclk = 1'b1; wcyc(H); sclk = 1'b0;
  endtask

  task automatic send(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) clk_bit(b[i]);
  endtask

  task automatic frame(input logic [7:0] b, input int n);
    sel(); send(b, n); desel(); wcyc(12);
  endtask

  // Wait for code to appear, count its length, check the state after it.
  task automatic measure(input logic [1:0] code, input int len,
                         input logic [1:0] nxt, input string req);
    int w = 0, c = 0;
    while (st != code && w < 30) begin wcyc(1); w++; end
    while (st == code && c < 2000) begin wcyc(1); c++; end
    check(c == len, req, c, len);
    check(st == nxt, req, st, nxt);
  endtask

  task automatic read_id(input int nbits, input string req);
    logic [7:0] exp_b;
    for (int k = 0; k < nbits; k++) begin
      if (k > 0) begin sclk = 1'b1; wcyc(H); sclk = 1'b0; end
      wcyc(H);
      exp_b = ID;
      check(do_oe === 1'b1, req, do_oe, 1);
      check(do_w === exp_b[7 - (k % 8)], req, do_w, exp_b[7 - (k % 8)]);
    end
  endtask

  task automatic t_reset();
    check(st == 2'b00, "R1 state", st, 0);
    check(do_oe == 1'b0, "R1 oe", do_oe, 0);
  endtask

  task automatic t_bad_length();
    frame(8'hB9, 7);
    check(st == 2'b00, "R3 seven bits", st, 0);
    sel(); send(8'hB9, 8); clk_bit(1'b0); desel(); wcyc(12);
    check(st == 2'b00, "R3 nine bits", st, 0);
  endtask

  task automatic t_busy();
    busy = 1'b1;
    frame(8'hB9, 8);
    check(st == 2'b00, "R4 busy", st, 0);
    busy = 1'b0;
  endtask

  task automatic t_ab_standby();
    frame(8'hAB, 8);
    check(st == 2'b00, "R11 bare wake", st, 0);
  endtask

  task automatic t_id_standby();
    sel(); send(8'hAB, 8); send(8'h00, 8); send(8'h00, 8); send(8'h00, 8);
    read_id(16, "R7 standby");
    desel(); wcyc(5);
    check(do_oe == 1'b0, "R9 oe after cs", do_oe, 0);
    wcyc(10);
    check(st == 2'b00, "R8 standby id", st, 0);
  endtask

  task automatic t_enter();
    sel(); send(8'hB9, 8); desel();
    measure(2'b01, T_DP, 2'b10, "R2 entry delay");
  endtask

  task automatic t_deep_ignore();
    frame(8'h9F, 8);
    check(st == 2'b10, "R5 other opcode", st, 2);
    frame(8'hB9, 8);
    check(st == 2'b10, "R5 sleep again", st, 2);
    frame(8'hAB, 7);
    check(st == 2'b10, "R5 short wake", st, 2);
    check(do_oe == 1'b0, "R5 oe", do_oe, 0);
  endtask

  task automatic t_release();
    sel(); send(8'hAB, 8); desel();
    measure(2'b11, T_RES1, 2'b00, "R6 wake delay");
  endtask

  task automatic t_id_deep();
    t_enter();
    sel(); send(8'hAB, 8); send(8'hFF, 8); send(8'h00, 8); send(8'h5A, 8);
    read_id(8, "R7 deep");
    check(st == 2'b10, "R8 still deep while reading", st, 2);
    desel();
    measure(2'b11, T_RES2, 2'b00, "R8 id exit delay");
    check(do_oe == 1'b0, "R9 oe idle", do_oe, 0);
  endtask

  task automatic t_transit();
    int w = 0;
    sel(); send(8'hB9, 8); desel();
    while (st != 2'b01 && w < 30) begin wcyc(1); w++; end
    frame(8'hAB, 8);
    w = 0;
    while (st == 2'b01 && w < 400) begin wcyc(1); w++; end
    wcyc(40);
    check(st == 2'b10, "R10 wake during entry ignored", st, 2);
    t_release();
  endtask

  initial begin
    wcyc(5);
    rst_n = 1'b1;
    wcyc(5);
    t_reset();
    t_bad_length();
    t_busy();
    t_ab_standby();
    t_id_standby();
    t_enter();
    t_deep_ignore();
    t_release();
    t_id_deep();
    t_transit();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule